// File: doc/BRIEF.md
# Data Access Alignment and Lane Steering Unit

This block sits between a processor core and a 32-bit wide data memory. The core presents one access per cycle: an effective address, a read or write flag, an access size (word, half or byte) and, for reads, a signed or unsigned select. The block checks that the address suits the size. A misaligned access raises a trap in the same cycle and produces no memory request. A legal access produces a word-aligned memory address, a write flag and byte-lane enables. For writes it also produces the store data shifted into the addressed lane.

Memory read data comes back one cycle after the address is issued. When a legal load is accepted, the block captures the two low address bits, the size and the signed select in a byte-offset register. On the next cycle it uses that registered state to pick the addressed byte or half out of the returned word and to extend it to 32 bits. It does not use the address the core presents in that later cycle. Lanes are big-endian: offset 0 is the most significant byte.

Top module: `lsu_align_unit`

## Requirements
- R1: Size encoding on `req_size` is 00 byte, 01 half, 10 word, and 11 is treated as a word. A word is legal only at offset 00. A half is legal at offsets 00 and 10. A byte is legal at any offset. `trap` is high in the same cycle as `req_valid` with an illegal offset, and low otherwise.
- R2: A trapped access drives `mem_en` low, `mem_we` low and `mem_be` to 0000, and gives no `ld_valid` in the next cycle.
- R3: Store data is placed big-endian. A byte at offset a goes to bits [31-8a : 24-8a]. A half at offset 00 goes to bits 31:16 and a half at offset 10 goes to bits 15:0. A word is passed unchanged.
- R4: Bit 3 of `mem_be` covers bits 31:24 and bit 0 covers bits 7:0. A legal access gives 1111 for a word, 1100 or 0011 for a half at offset 00 or 10, and 1000 shifted right by the offset for a byte.
- R5: The two low address bits of an accepted load are held in a byte-offset register. The data returned in the next cycle is steered by that registered offset, not by the address presented in the cycle the data returns.
- R6: Unsigned byte and half loads are zero-extended to 32 bits.
- R7: Signed byte and half loads are sign-extended from bit 7 or bit 15 of the selected value.
- R8: A word load returns `mem_rdata` unchanged, whatever the signed select.
- R9: `ld_valid` is high exactly one cycle after a legal load is accepted. After a synchronous active-low reset, `ld_valid` is low.
- R10: `mem_addr` equals `req_addr` with its two low bits cleared. `mem_en` is high for a legal request, and `mem_we` is high only for a legal write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access presented this cycle |
| req_write | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | 00 byte, 01 half, 10/11 word |
| req_signed | input | 1 | Sign-extend a byte or half load |
| req_addr | input | AW (32) | Effective byte address |
| st_data | input | 32 | Store data, right-aligned |
| mem_rdata | input | 32 | Memory read word, valid one cycle after a load |
| mem_en | output | 1 | Memory request for a legal access |
| mem_we | output | 1 | Memory write for a legal store |
| mem_addr | output | AW (32) | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-shifted store data |
| trap | output | 1 | Misaligned access |
| ld_valid | output | 1 | Extracted load data valid |
| ld_data | output | 32 | Extracted and extended load data |

## Verification
Two functions can fall in the same cycle. The extraction of the previous load's returned word can coincide with the alignment check and lane steering of a new access whose low address bits differ. The bench provokes this by issuing accesses back to back: loads followed by stores, by other loads, and by misaligned requests at a different offset. A behavioural reference model keeps the offset, size and sign of the pending load in its own variables. Each cycle, the model compares `ld_data` against the value taken from the remembered offset, while it checks the current request's trap, enables and store data against the current address.

// File: rtl/lsu_align_pkg.sv
// Shared types for the data access alignment unit.
package lsu_align_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } acc_size_e;
endpackage

// File: rtl/lsu_align_check.sv
// Alignment checker and byte-lane enable generator.
// Assumes big-endian lanes: lane_be[LANES-1] covers the most significant byte.
// Size code 11 is handled as a word.
module lsu_align_check #(
    parameter int DW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          size_i,
    input  logic [1:0]          lo_i,
    output logic                misalign_o,
    output logic [DW/8-1:0]     lane_be_o
);
    import lsu_align_pkg::*;
    localparam int LANES = DW / 8;
    localparam int HALF_LANES = LANES / 2;

    logic [LANES-1:0] byte_be;
    logic [LANES-1:0] half_hi_be;

    // one-hot byte enable: offset 0 selects the top lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign byte_be[g]    = (int'(lo_i) == LANES - 1 - g);
        assign half_hi_be[g] = (g >= HALF_LANES);
    end

    // legality and enable pattern per size
    always_comb begin
        case (acc_size_e'(size_i))
            SZ_BYTE: begin
                misalign_o = 1'b0;
                lane_be_o  = byte_be;
            end
            SZ_HALF: begin
                misalign_o = lo_i[0];
                lane_be_o  = lo_i[1] ? ~half_hi_be : half_hi_be;
            end
            default: begin
                misalign_o = (lo_i != 2'b00);
                lane_be_o  = '1;
            end
        endcase
    end

    // word accesses at a legal offset enable every lane (R4)
    p_word_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i[1] && !misalign_o) |-> (lane_be_o == '1));

    // half at an odd offset is always illegal (R1)
    p_half_odd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'b01 && lo_i[0]) |-> misalign_o);

    // a legal half uses exactly two lanes (R4)
    p_half_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'b01 && !misalign_o) |-> ($countones(lane_be_o) == 2));
endmodule

// File: rtl/lsu_store_lane.sv
// Store data lane shifter: moves a right-aligned byte or half into the
// big-endian lane selected by the low address bits. Words pass through.
module lsu_store_lane #(
    parameter int DW = 32
) (
    input  logic [1:0]    size_i,
    input  logic [1:0]    lo_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o
);
    import lsu_align_pkg::*;
    localparam int LANES = DW / 8;

    // shift distance follows the lane position counted from the top
    always_comb begin
        case (acc_size_e'(size_i))
            SZ_BYTE: data_o = DW'(data_i[7:0]) << (8 * (LANES - 1 - int'(lo_i)));
            SZ_HALF: data_o = lo_i[1] ? DW'(data_i[15:0]) : (DW'(data_i[15:0]) << (DW / 2));
            default: data_o = data_i;
        endcase
    end
endmodule

// File: rtl/lsu_load_extract.sv
// Load data extractor: picks the byte or half addressed by the registered
// offset out of the returned word and zero- or sign-extends it.
// Assumes the offset, size and sign inputs are the values latched with the load.
module lsu_load_extract #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [1:0]    size_i,
    input  logic          sgn_i,
    input  logic [1:0]    lo_i,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] data_o
);
    import lsu_align_pkg::*;
    localparam int LANES = DW / 8;

    logic [7:0]  sel_byte;
    logic [15:0] sel_half;
    logic [DW-1:0] shifted;

    // lane selection, big-endian
    always_comb begin
        shifted  = rdata_i >> (8 * (LANES - 1 - int'(lo_i)));
        sel_byte = shifted[7:0];
        sel_half = lo_i[1] ? rdata_i[15:0] : rdata_i[DW-1:DW-16];
    end

    // extension by size and sign select
    always_comb begin
        case (acc_size_e'(size_i))
            SZ_BYTE: data_o = {{(DW-8){sgn_i & sel_byte[7]}}, sel_byte};
            SZ_HALF: data_o = {{(DW-16){sgn_i & sel_half[15]}}, sel_half};
            default: data_o = rdata_i;
        endcase
    end

    // unsigned byte loads carry no upper bits (R6)
    p_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !sgn_i && size_i == 2'b00) |-> (data_o[DW-1:8] == '0));

    // signed half loads replicate bit 15 upward (R7)
    p_sign_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && sgn_i && size_i == 2'b01) |-> (data_o[DW-1:16] == {(DW-16){data_o[15]}}));

    // word loads leave the returned word untouched (R8)
    p_word_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && size_i[1]) |-> (data_o == rdata_i));
endmodule

// File: rtl/lsu_align_unit.sv
// Data access alignment unit top. Checks alignment, steers store lanes,
// drives the memory request, and latches the byte offset of an accepted
// load so that the word returned one cycle later can be extracted.
// Assumes memory read data is valid exactly one cycle after mem_en for a load.
module lsu_align_unit #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [1:0]      req_size,
    input  logic            req_signed,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   st_data,
    input  logic [DW-1:0]   mem_rdata,
    output logic            mem_en,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0]   mem_wdata,
    output logic            trap,
    output logic            ld_valid,
    output logic [DW-1:0]   ld_data
);
    localparam int LANES = DW / 8;

    logic             misalign;
    logic [LANES-1:0] lane_be;
    logic             accept;
    logic             ld_accept;
    logic [1:0]       bar_q;
    logic [1:0]       size_q;
    logic             sgn_q;
    logic             vld_q;

    lsu_align_check #(.DW(DW)) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_i    (req_size),
        .lo_i      (req_addr[1:0]),
        .misalign_o(misalign),
        .lane_be_o (lane_be)
    );

    lsu_store_lane #(.DW(DW)) u_store (
        .size_i(req_size),
        .lo_i  (req_addr[1:0]),
        .data_i(st_data),
        .data_o(mem_wdata)
    );

    // request gating: a trapped access makes no memory request
    always_comb begin
        accept    = req_valid & ~misalign;
        ld_accept = accept & ~req_write;
        trap      = req_valid & misalign;
        mem_en    = accept;
        mem_we    = accept & req_write;
        mem_be    = accept ? lane_be : '0;
        mem_addr  = {req_addr[AW-1:2], 2'b00};
    end

    // byte-offset register and pending-load state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            bar_q  <= 2'b00;
            size_q <= 2'b10;
            sgn_q  <= 1'b0;
        end else begin
            vld_q <= ld_accept;
            if (ld_accept) begin
                bar_q  <= req_addr[1:0];
                size_q <= req_size;
                sgn_q  <= req_signed;
            end
        end
    end

    lsu_load_extract #(.DW(DW)) u_extract (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (vld_q),
        .size_i (size_q),
        .sgn_i  (sgn_q),
        .lo_i   (bar_q),
        .rdata_i(mem_rdata),
        .data_o (ld_data)
    );

    assign ld_valid = vld_q;

    // a trap suppresses every memory side effect (R2)
    p_trap_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!mem_en && !mem_we && mem_be == '0));

    // an accepted load yields valid data on the next cycle (R9)
    p_load_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> ld_valid);

    // a trapped request never yields load data (R2)
    p_trap_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !ld_valid);

    // returning data is steered by the offset of the issuing cycle (R5)
    p_bar_steer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> (bar_q == $past(req_addr[1:0])));
endmodule

// File: tb/sim_lsu_align_unit.sv
`timescale 1ns/1ps
module sim_lsu_align_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_signed = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] st_data = '0;
    logic [31:0] mem_rdata = '0;
    logic        mem_en, mem_we, trap, ld_valid;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [3:0]  mem_be;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state for the load in flight
    bit         pend = 0;
    int         p_off = 0;
    int         p_size = 0;
    bit         p_sgn = 0;

    always #4 clk = ~clk;

    lsu_align_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
        .st_data(st_data), .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .trap(trap),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit m_trap(int sz, int off);
        if (sz == 0) return 0;
        if (sz == 1) return (off % 2) != 0;
        return off != 0;
    endfunction

    function automatic logic [31:0] m_be(int sz, int off);
        if (sz == 0) return 32'(8 >> off);
        if (sz == 1) return (off == 0) ? 32'hC : 32'h3;
        return 32'hF;
    endfunction

    function automatic logic [31:0] m_wdata(int sz, int off, logic [31:0] d);
        if (sz == 0) return {24'h0, d[7:0]} << ((3 - off) * 8);
        if (sz == 1) return (off == 0) ? {d[15:0], 16'h0} : {16'h0, d[15:0]};
        return d;
    endfunction

    function automatic logic [31:0] m_load(int sz, int off, bit sg, logic [31:0] w);
        longint v;
        if (sz == 0) begin
            v = (w >> ((3 - off) * 8)) & 255;
            if (sg && v >= 128) v = v - 256;
        end else if (sz == 1) begin
            v = (off == 0) ? (w >> 16) : (w & 32'hFFFF);
            if (sg && v >= 32768) v = v - 65536;
        end else begin
            v = w;
        end
        return 32'(v);
    endfunction

    // one cycle: drive at the falling edge, check just before the rising edge
    task automatic step(input bit v, input bit w, input int sz, input bit sg,
                        input logic [31:0] a, input logic [31:0] d, input logic [31:0] rd);
        int off;
        bit et;
        string rtag;
        @(negedge clk);
        req_valid = v; req_write = w; req_size = 2'(sz); req_signed = sg;
        req_addr = a; st_data = d; mem_rdata = rd;
        off = int'(a[1:0]);
        et = v && m_trap(sz, off);
        #3;
        chk("R1 trap", {31'h0, trap}, {31'h0, et});
        chk("R10 mem_en", {31'h0, mem_en}, {31'h0, v && !et});
        chk("R10 mem_we", {31'h0, mem_we}, {31'h0, v && w && !et});
        chk("R10 mem_addr", mem_addr, {a[31:2], 2'b00});
        if (v && !et) chk("R4 mem_be", {28'h0, mem_be}, m_be(sz, off));
        else          chk("R2 mem_be quiet", {28'h0, mem_be}, 32'h0);
        if (v && w && !et) chk("R3 mem_wdata", mem_wdata, m_wdata(sz, off, d));
        chk("R9 ld_valid", {31'h0, ld_valid}, {31'h0, pend});
        if (pend) begin
            rtag = (p_size >= 2) ? "R8 word load" : (p_sgn ? "R7 signed load" : "R6 unsigned load");
            chk({rtag, " (R5 offset)"}, ld_data, m_load(p_size, p_off, p_sgn, rd));
        end
        @(posedge clk);
        pend   = rst_n && v && !w && !et;
        p_off  = off;
        p_size = sz;
        p_sgn  = sg;
        #1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset ld_valid", {31'h0, ld_valid}, 32'h0);
        chk("R10 reset mem_en", {31'h0, mem_en}, 32'h0);
        chk("R1 reset trap", {31'h0, trap}, 32'h0);
        rst_n = 1'b1;

        // R1/R2: misaligned words and halves, legal bytes at every offset
        step(1, 0, 2, 0, 32'h100, 0, 0);
        step(1, 1, 2, 0, 32'h101, 32'hDEADBEEF, 0);
        step(1, 1, 1, 0, 32'h103, 32'h1234, 0);
        step(1, 0, 3, 0, 32'h102, 0, 32'h11223344);
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 32'h200 + i, 32'hA5, 0);
        // R3/R4: half stores at both legal offsets
        step(1, 1, 1, 0, 32'h300, 32'hCAFEBABE, 0);
        step(1, 1, 1, 0, 32'h302, 32'hCAFEBABE, 0);
        // R5: back-to-back loads at different offsets, data steered by the prior one
        step(1, 0, 0, 1, 32'h403, 0, 0);
        step(1, 0, 0, 0, 32'h400, 0, 32'h8899AAFF);
        step(1, 1, 1, 0, 32'h402, 32'h5555, 32'hF0E1D2C3);
        // R7: signed half with negative value, then R6 unsigned half
        step(1, 0, 1, 1, 32'h500, 0, 0);
        step(1, 0, 1, 0, 32'h502, 0, 32'h8001_7FFF);
        step(1, 0, 2, 1, 32'h504, 0, 32'hFEDC_8001);
        // R8: word load with signed select set, followed by a trapped load
        step(1, 0, 1, 0, 32'h601, 0, 32'h8765_4321);
        step(0, 0, 0, 0, 32'h0, 0, 32'h1);
        // random mix
        for (int i = 0; i < 400; i++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 3), $urandom_range(0, 1) == 1,
                 $urandom, $urandom, $urandom);
        // reset clears a pending load (R9)
        step(1, 0, 2, 0, 32'h700, 0, 0);
        rst_n = 1'b0;
        step(0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 32'h12345678);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule